// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer and Peripheral Decoder

This block sits beside a small 8-bit controller whose low address byte and data share one bus. The controller raises an address strobe while it puts the address out. It then lowers the strobe once the lines have settled, and raises a data strobe for the transfer. The block keeps the low address byte on a steady output for the whole access. It also passes the dedicated high address lines through, so that downstream logic sees a full 13-bit address.

From that full address the block derives two kinds of enable. When the upper four address bits are all zero, the access falls in a peripheral window. There, three address bits choose one of eight active-low selects. The selects drive a counter chip, an interface address decoder, a write strobe and two output latches. Outside the window, an active-low ROM enable is asserted instead. The selects can only be active while the data strobe is high and an external block input is low. The ROM enable needs only the data strobe. Both enables are registered on the block clock, and the strobes are taken to be synchronous to that clock.

Top module: `mux_bus_demux`

## Requirements
- R1: While rst_ni is low, all sel_no bits and rom_ce_no are 1, and the held low byte is 0. With as_i low, addr_lo_o reads 0.
- R2: While as_i is 1, addr_lo_o equals b_i in the same cycle (transparent).
- R3: While as_i is 0, addr_lo_o holds the b_i value captured at the last rising clock edge at which as_i was 1, whatever b_i does. addr_hi_o always equals addr_hi_i.
- R4: sel_no and rom_ce_no change only at the rising clock edge. At each edge they take the value decoded from the inputs present at that edge, so they lag the inputs by one cycle.
- R5: A clock edge that samples ds_i = 0 (address phase) leaves every sel_no bit at 1 and rom_ce_no at 1.
- R6: A clock edge that samples gate_i = 1 leaves every sel_no bit at 1. The gate input has no effect on rom_ce_no.
- R7: The full address is {addr_hi_i, addr_lo_o}, with bit 12 the MSB. An edge that samples any of bits 12..9 nonzero leaves every sel_no bit at 1.
- R8: An edge that samples ds_i = 1, gate_i = 0 and bits 12..9 all zero drives exactly sel_no[k] low, where k = bits 8..6. For example, 110 drives sel_no[6] low and 111 drives sel_no[7] low.
- R9: rom_ce_no is 0 after an edge that samples ds_i = 1 with any of bits 12..9 nonzero, and 1 otherwise.
- R10: At most one sel_no bit is 0 at any time, and rom_ce_no is never 0 while a sel_no bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_i | input | 1 | Address strobe, high during the address phase |
| ds_i | input | 1 | Data strobe, high during the data transfer phase |
| gate_i | input | 1 | External gating term; high blocks all selects |
| b_i | input | 8 | Shared low address / data bus |
| addr_hi_i | input | 5 | High address lines, bits 12..8 |
| addr_lo_o | output | 8 | Demultiplexed low address byte |
| addr_hi_o | output | 5 | High address lines passed through |
| sel_no | output | 8 | Active-low peripheral selects, indexed by bits 8..6 |
| rom_ce_no | output | 1 | Active-low ROM enable |

## Verification
The bench builds the block with its default sizes: an 8-bit low byte, 5 high lines, and a 3-bit select field starting at bit 6. At these sizes all eight select codes and every pattern of the four window bits can be reached with full bus cycles. A reference model computes the expected values cycle by cycle and is compared on every clock. It runs directed cycles that walk each select code, block them with the gate, and address outside the window. Random cycles follow, with bus data that changes during the hold phase to probe the latch.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  localparam int DEF_LO_W    = 8;
  localparam int DEF_HI_W    = 5;
  localparam int DEF_DEC_LSB = 6;
  localparam int DEF_SEL_W   = 3;

  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_DATA  = 2'd1,
    PH_GATED = 2'd2
  } bus_phase_e;

  function automatic bus_phase_e classify(input logic ds, input logic gate);
    if (!ds)      return PH_ADDR;
    else if (gate) return PH_GATED;
    else          return PH_DATA;
  endfunction
endpackage

// File: rtl/bus_lo_latch.sv
module bus_lo_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         as_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   held_q <= '0;
    else if (as_i) held_q <= b_i;
  end

  // transparent while strobe high, frozen after it falls
  assign q_o = as_i ? b_i : held_q;
endmodule

// File: rtl/bus_window_decode.sv
module bus_window_decode
  import mux_bus_pkg::*;
#(
  parameter int AW      = 13,
  parameter int DEC_LSB = 6,
  parameter int SEL_W   = 3,
  localparam int NSEL    = 1 << SEL_W,
  localparam int WIN_LSB = DEC_LSB + SEL_W
) (
  input  logic [AW-1:0]   addr_i,
  input  logic            ds_i,
  input  logic            gate_i,
  output logic [NSEL-1:0] sel_n_o,
  output logic            rom_n_o
);
  bus_phase_e       phase;
  logic             in_win;
  logic [SEL_W-1:0] idx;
  logic             hit;

  assign phase  = classify(ds_i, gate_i);
  assign in_win = ~|addr_i[AW-1:WIN_LSB];
  assign idx    = addr_i[WIN_LSB-1:DEC_LSB];
  assign hit    = (phase == PH_DATA) && in_win;

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    assign sel_n_o[i] = ~(hit && (idx == SEL_W'(i)));
  end

  assign rom_n_o = ~(ds_i && !in_win);
endmodule

// File: rtl/bus_sel_reg.sv
module bus_sel_reg #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '1;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/mux_bus_demux.sv
module mux_bus_demux
  import mux_bus_pkg::*;
#(
  parameter int LO_W    = DEF_LO_W,
  parameter int HI_W    = DEF_HI_W,
  parameter int DEC_LSB = DEF_DEC_LSB,
  parameter int SEL_W   = DEF_SEL_W,
  localparam int AW      = LO_W + HI_W,
  localparam int NSEL    = 1 << SEL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            as_i,
  input  logic            ds_i,
  input  logic            gate_i,
  input  logic [LO_W-1:0] b_i,
  input  logic [HI_W-1:0] addr_hi_i,
  output logic [LO_W-1:0] addr_lo_o,
  output logic [HI_W-1:0] addr_hi_o,
  output logic [NSEL-1:0] sel_no,
  output logic            rom_ce_no
);
  logic [AW-1:0]   addr_full;
  logic [NSEL-1:0] sel_n_d;
  logic            rom_n_d;
  logic [NSEL:0]   en_q;

  bus_lo_latch #(.W(LO_W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .as_i  (as_i),
    .b_i   (b_i),
    .q_o   (addr_lo_o)
  );

  assign addr_hi_o = addr_hi_i;
  assign addr_full = {addr_hi_i, addr_lo_o};

  bus_window_decode #(.AW(AW), .DEC_LSB(DEC_LSB), .SEL_W(SEL_W)) u_dec (
    .addr_i (addr_full),
    .ds_i   (ds_i),
    .gate_i (gate_i),
    .sel_n_o(sel_n_d),
    .rom_n_o(rom_n_d)
  );

  bus_sel_reg #(.W(NSEL + 1)) u_oreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rom_n_d, sel_n_d}),
    .q_o   (en_q)
  );

  assign sel_no    = en_q[NSEL-1:0];
  assign rom_ce_no = en_q[NSEL];
endmodule

// File: rtl/mux_bus_checker.sv
module mux_bus_checker #(
  parameter int LO_W    = 8,
  parameter int HI_W    = 5,
  parameter int DEC_LSB = 6,
  parameter int SEL_W   = 3,
  localparam int AW      = LO_W + HI_W,
  localparam int NSEL    = 1 << SEL_W,
  localparam int WIN_LSB = DEC_LSB + SEL_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            as_i,
  input logic            ds_i,
  input logic            gate_i,
  input logic [LO_W-1:0] b_i,
  input logic [HI_W-1:0] addr_hi_i,
  input logic [LO_W-1:0] addr_lo_o,
  input logic [NSEL-1:0] sel_no,
  input logic            rom_ce_no
);
  logic [AW-1:0] full;
  assign full = {addr_hi_i, addr_lo_o};

  AST_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_i |-> addr_lo_o == b_i); // R2
  AST_HOLD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_i && $past(!as_i)) |-> $stable(addr_lo_o)); // R3
  AST_ADDR_PHASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ds_i |=> (sel_no == '1 && rom_ce_no)); // R5
  AST_GATE_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i |=> sel_no == '1); // R6
  AST_OUT_OF_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|full[AW-1:WIN_LSB]) |=> sel_no == '1); // R7
  AST_ONE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~sel_no) <= 1); // R10
  AST_SEL_ROM_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_ce_no == 1'b0 && sel_no != '1)); // R10
endmodule

bind mux_bus_demux mux_bus_checker #(
  .LO_W(LO_W), .HI_W(HI_W), .DEC_LSB(DEC_LSB), .SEL_W(SEL_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .as_i(as_i), .ds_i(ds_i), .gate_i(gate_i),
  .b_i(b_i), .addr_hi_i(addr_hi_i), .addr_lo_o(addr_lo_o),
  .sel_no(sel_no), .rom_ce_no(rom_ce_no)
);

// File: tb/mux_bus_demux_test.sv
`timescale 1ns/1ps
module mux_bus_demux_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       as = 0, ds = 0, gate = 0;
  logic [7:0] b = 0;
  logic [4:0] hi = 0;
  logic [7:0] lo_o;
  logic [4:0] hi_o;
  logic [7:0] sel_n;
  logic       rom_n;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mux_bus_demux uut (
    .clk_i(clk), .rst_ni(rst_n), .as_i(as), .ds_i(ds), .gate_i(gate),
    .b_i(b), .addr_hi_i(hi), .addr_lo_o(lo_o), .addr_hi_o(hi_o),
    .sel_no(sel_n), .rom_ce_no(rom_n)
  );

  // behavioural reference
  int    m_held = 0;
  int    m_sel  = 255;
  int    m_rom  = 1;
  string m_tag  = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_held <= 0; m_sel <= 255; m_rom <= 1; m_tag <= "R1";
    end else begin
      int lo_now, full;
      bit win;
      lo_now = as ? int'(b) : m_held;
      full   = (int'(hi) << 8) | lo_now;
      win    = (full >> 9) == 0;
      if (!ds)        begin m_sel <= 255; m_tag <= "R5"; end
      else if (gate)  begin m_sel <= 255; m_tag <= "R6"; end
      else if (!win)  begin m_sel <= 255; m_tag <= "R7"; end
      else begin
        m_sel <= 255 & ~(1 << ((full >> 6) & 7)); m_tag <= "R8";
      end
      m_rom  <= (ds && !win) ? 0 : 1;
      if (as) m_held <= int'(b);
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle compare, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(as ? "R2" : "R3", int'(lo_o), as ? int'(b) : m_held);
      check("R3 hi pass", int'(hi_o), int'(hi));
      check({m_tag, " R4"}, int'(sel_n), m_sel);
      check("R9", int'(rom_n), m_rom);
    end
  end

  task automatic bus_cycle(input logic [4:0] h, input logic [7:0] l,
                           input logic g, input int ndata);
    @(negedge clk); as = 1; ds = 0; hi = h; b = l; gate = g;
    @(negedge clk); as = 0;
    @(negedge clk); ds = 1;
    for (int k = 0; k < ndata; k++) begin
      @(negedge clk); b = 8'($urandom);
    end
    @(negedge clk); ds = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    b = 8'hA5;
    repeat (3) @(posedge clk);
    #2;
    check("R1 lo", int'(lo_o), 0);
    check("R1 sel", int'(sel_n), 255);
    check("R1 rom", int'(rom_n), 1);
    @(negedge clk); rst_n = 1;

    // R8: walk every select code inside the window
    for (int k = 0; k < 8; k++) begin
      logic [8:0] a9;
      a9 = 9'(k) << 6;
      bus_cycle({4'b0, a9[8]}, a9[7:0] | 8'h15, 1'b0, 2);
    end

    // directed Y6 / Y7 and hold-while-data checks
    @(negedge clk); as = 1; ds = 0; hi = 5'b00001; b = 8'h80; gate = 0;
    @(negedge clk); as = 0; b = 8'h3C;
    @(negedge clk); ds = 1; b = 8'hFF;
    @(posedge clk); #2;
    check("R8 code110", int'(sel_n), 8'hBF);
    check("R3 hold", int'(lo_o), 8'h80);
    check("R10 rom off", int'(rom_n), 1);
    @(negedge clk); b = 8'h00;
    @(posedge clk); #2;
    check("R3 hold2", int'(lo_o), 8'h80);
    @(negedge clk); ds = 0;
    @(posedge clk); #2;
    check("R5 idle", int'(sel_n), 255);
    @(negedge clk); as = 1; hi = 5'b00001; b = 8'hC0;
    @(posedge clk); #2;
    check("R2 transp", int'(lo_o), 8'hC0);
    @(negedge clk); as = 0; b = 8'h11;
    @(negedge clk); ds = 1;
    @(posedge clk); #2;
    check("R8 code111", int'(sel_n), 8'h7F);
    // R6: gate blocks but leaves ROM alone
    @(negedge clk); gate = 1;
    @(posedge clk); #2;
    check("R6 gated", int'(sel_n), 255);
    check("R6 rom", int'(rom_n), 1);
    @(negedge clk); ds = 0; gate = 0;

    // R7 / R9: outside the window
    @(negedge clk); as = 1; hi = 5'b10000; b = 8'h40;
    @(negedge clk); as = 0;
    @(negedge clk); ds = 1; gate = 1;
    @(posedge clk); #2;
    check("R9 rom on", int'(rom_n), 0);
    check("R7 no sel", int'(sel_n), 255);
    @(negedge clk); ds = 0; gate = 0;
    @(posedge clk); #2;
    check("R5 rom off", int'(rom_n), 1);

    // random bus cycles
    for (int n = 0; n < 400; n++) begin
      logic [4:0] h;
      h = ($urandom_range(0, 2) == 0) ? 5'($urandom) : {4'b0, 1'($urandom)};
      bus_cycle(h, 8'($urandom), 1'($urandom_range(0, 3) == 0),
                int'($urandom_range(0, 3)));
    end

    // mid-run reset
    @(negedge clk); as = 0; ds = 1; rst_n = 0;
    #1;
    check("R1 async sel", int'(sel_n), 255);
    check("R1 async rom", int'(rom_n), 1);
    check("R1 async lo", int'(lo_o), 0);
    @(negedge clk); rst_n = 1; ds = 0;
    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule